// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Idle Gating

This block is a watchdog for a small microcontroller-style core. The oscillator clock is divided into machine cycles, which feed a prescaler with eight selectable ratios. The prescaler in turn drives a wide overflow timer. Unless software restarts the chain through a self-clearing clear bit before the timer wraps, the block raises a one-cycle internal reset request and sets a sticky timeout flag.

The core controls the block through one byte-wide control register. It writes the register with `wr_en`/`wr_data` and reads it back on `ctrl_rd`. The core also supplies an idle-mode indication and an instruction-cycle strobe. A pending clear is applied at the next strobe. While the core idles, counting stops unless the idle-run bit is set. The reset request resets the watchdog itself, together with whatever else the chip hangs on it.

Control register layout (read and write): bit 7 enable, bit 6 clear request, bit 5 idle-run, bit 4 reads 0, bit 3 timeout flag, bits 2:0 prescaler select.

Top module: `wdt_prescaled`

## Requirements
- R1: After external reset, `ctrl_rd` reads 0x00, `wdt_rst` is 0 and `timeout` is 0.
- R2: With the block enabled and not idle, the reset pulse appears OSC_DIV × ratio × 2^TMR_W clock edges after the write that enabled it. The select code maps to the ratio as follows: 000→2, 010→4, 001→8, 011→16, 100→32, 101→64, 110→128, 111→256.
- R3: Overflow produces a `wdt_rst` pulse exactly one cycle wide and sets `timeout`. In the same cycle, enable, idle-run, clear and select are cleared, so `ctrl_rd` reads 0x08.
- R4: `timeout` stays set until a write with bit 3 = 0. A write with bit 3 = 1 leaves it unchanged. Only external reset clears it otherwise.
- R5: Writing 1 to bit 6 makes bit 6 read 1. At the first later edge where `instr_stb` is high, the divider, prescaler and timer restart from zero and bit 6 reads 0 again.
- R6: Writing 0 to bit 6 has no effect on the count.
- R7: While enable is 0, no reset pulse occurs and the divider, prescaler and timer are held at zero. Re-enabling therefore yields a full period.
- R8: While `idle` is high and idle-run is 0, counting is frozen without loss. With idle-run at 1, idle has no effect.
- R9: A change of the select code while the prescaler is mid-period takes effect from the next prescaler wrap and does not clear the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| idle | input | 1 | Core is in idle mode |
| instr_stb | input | 1 | Instruction-cycle strobe, applies a pending clear |
| ctrl_rd | output | 8 | Control register read value |
| wdt_rst | output | 1 | One-cycle internal reset request |
| timeout | output | 1 | Sticky timeout flag |

## Verification
The bench keeps OSC_DIV at 12 and shrinks TMR_W to 4. This makes the longest period 49,152 cycles, so every select code can be run to overflow and its count compared against the full product. Because the timer has only sixteen steps, a select change part-way through the first prescaler period produces a distinct, hand-computable total. The clear and idle-freeze offsets likewise stay exact and visible.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int OSC_DIV = 12,
  parameter int TMR_W   = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       idle,
  input  logic       instr_stb,
  output logic [7:0] ctrl_rd,
  output logic       wdt_rst,
  output logic       timeout
);
  localparam int DIV_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam int PRE_W = 8;

  logic             en_q, idle_run_q, clr_pend_q, flag_q, pulse_q;
  logic [2:0]       sel_q, sel_act_q, sel_eff;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, pre_top;
  logic [TMR_W-1:0] tmr_q;
  logic             active, mtick, pwrap, ovf, do_clr;

  function automatic int sel_shift(input logic [2:0] s);
    case (s)
      3'b001:  return 3;
      3'b010:  return 2;
      default: return int'(s) + 1;
    endcase
  endfunction

  assign sel_eff = (pre_q == '0) ? sel_q : sel_act_q;
  assign pre_top = PRE_W'((1 << sel_shift(sel_eff)) - 1);
  assign active  = en_q & (~idle | idle_run_q);
  assign mtick   = active & (div_q == DIV_W'(OSC_DIV - 1));
  assign pwrap   = mtick & (pre_q == pre_top);
  assign ovf     = pwrap & (&tmr_q);
  assign do_clr  = clr_pend_q & instr_stb;

  assign ctrl_rd = {en_q, clr_pend_q, idle_run_q, 1'b0, flag_q, sel_q};
  assign wdt_rst = pulse_q;
  assign timeout = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; idle_run_q <= 1'b0; clr_pend_q <= 1'b0; flag_q <= 1'b0;
      pulse_q <= 1'b0; sel_q <= '0; sel_act_q <= '0;
      div_q <= '0; pre_q <= '0; tmr_q <= '0;
    end else begin
      pulse_q <= ovf;
      if (ovf) begin
        en_q <= 1'b0; idle_run_q <= 1'b0; clr_pend_q <= 1'b0; flag_q <= 1'b1;
        sel_q <= '0; sel_act_q <= '0;
        div_q <= '0; pre_q <= '0; tmr_q <= '0;
      end else begin
        sel_act_q <= sel_eff;
        if (wr_en) begin
          en_q       <= wr_data[7];
          idle_run_q <= wr_data[5];
          sel_q      <= wr_data[2:0];
          if (!wr_data[3]) flag_q <= 1'b0;
        end
        if (wr_en && wr_data[6]) clr_pend_q <= 1'b1;
        else if (do_clr)         clr_pend_q <= 1'b0;
        if (!en_q || do_clr) begin
          div_q <= '0; pre_q <= '0; tmr_q <= '0;
        end else if (mtick) begin
          div_q <= '0;
          if (pwrap) begin
            pre_q <= '0;
            tmr_q <= tmr_q + 1'b1;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end else if (active) begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

module wdt_prescaled_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       instr_stb,
  input logic [7:0] ctrl_rd,
  input logic       wdt_rst,
  input logic       timeout
);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  p_flag_with_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (timeout && ctrl_rd == 8'h08));
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !(wr_en && !wr_data[3])) |=> timeout);
  p_clear_applies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[6] && instr_stb && !(wr_en && wr_data[6])) |=> !ctrl_rd[6]);
  p_no_ovf_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[7] |=> !wdt_rst);
  p_flag_rises_on_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> wdt_rst);
endmodule

bind wdt_prescaled wdt_prescaled_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .instr_stb(instr_stb), .ctrl_rd(ctrl_rd), .wdt_rst(wdt_rst), .timeout(timeout)
);

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb;
  localparam int OSC = 12;
  localparam int TW  = 4;
  localparam int STEPS = 1 << TW;
  localparam int RATIO_T [8] = '{2, 8, 4, 16, 32, 64, 128, 256};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, idle = 1'b0, instr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_rd;
  logic wdt_rst, timeout;
  int cyc = 0, pulses = 0, errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_prescaled #(.OSC_DIV(OSC), .TMR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .idle(idle),
    .instr_stb(instr_stb), .ctrl_rd(ctrl_rd), .wdt_rst(wdt_rst), .timeout(timeout));

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (wdt_rst) pulses <= pulses + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, output int t);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; t = cyc;
  endtask

  task automatic wait_pulse(input int t0, output int el);
    do @(negedge clk); while (!wdt_rst && (cyc - t0) < 60000);
    el = wdt_rst ? cyc - t0 : -1;
  endtask

  task automatic stb(output int t);
    @(negedge clk); instr_stb = 1'b1;
    @(negedge clk); instr_stb = 1'b0; t = cyc;
  endtask

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      check(0, "R2 watchdog", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t0, t1, el, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 0);
    check(!wdt_rst && !timeout, "R1 outputs", {wdt_rst, timeout}, 0);

    for (int k = 0; k < 8; k++) begin
      wr(8'h88 | 8'(k), t0);
      wait_pulse(t0, el);
      check(el == OSC * RATIO_T[k] * STEPS, "R2 period", el, OSC * RATIO_T[k] * STEPS);
      check(ctrl_rd == 8'h08 && timeout, "R3 state at pulse", ctrl_rd, 8'h08);
      @(negedge clk);
      check(!wdt_rst, "R3 single cycle", wdt_rst, 0);
    end

    wr(8'h08, t0);
    check(timeout, "R4 write 1 keeps", timeout, 1);
    wr(8'h00, t0);
    check(!timeout && ctrl_rd == 8'h00, "R4 write 0 clears", ctrl_rd, 0);

    wr(8'h80, t0);
    repeat (100) @(negedge clk);
    wr(8'hC0, t1);
    check(ctrl_rd[6], "R5 pending reads 1", ctrl_rd[6], 1);
    repeat (10) @(negedge clk);
    stb(t1);
    check(!ctrl_rd[6], "R5 pending cleared", ctrl_rd[6], 0);
    wait_pulse(t1, el);
    check(el == OSC * 2 * STEPS, "R5 restart", el, OSC * 2 * STEPS);

    wr(8'h80, t0);
    repeat (100) @(negedge clk);
    wr(8'h80, t1);
    stb(t1);
    wait_pulse(t0, el);
    check(el == OSC * 2 * STEPS, "R6 zero write ignored", el, OSC * 2 * STEPS);

    wr(8'h00, t0);
    p0 = pulses;
    repeat (1000) @(negedge clk);
    check(pulses == p0 && ctrl_rd == 8'h00, "R7 idle disabled", pulses - p0, 0);
    wr(8'h80, t0);
    repeat (200) @(negedge clk);
    wr(8'h00, t0);
    repeat (500) @(negedge clk);
    check(pulses == p0, "R7 no pulse after disable", pulses - p0, 0);
    wr(8'h80, t0);
    wait_pulse(t0, el);
    check(el == OSC * 2 * STEPS, "R7 full period after re-enable", el, OSC * 2 * STEPS);

    wr(8'h80, t0);
    repeat (50) @(negedge clk);
    idle = 1'b1;
    repeat (50) @(negedge clk);
    idle = 1'b0;
    wait_pulse(t0, el);
    check(el == OSC * 2 * STEPS + 50, "R8 frozen in idle", el, OSC * 2 * STEPS + 50);
    wr(8'hA0, t0);
    repeat (50) @(negedge clk);
    idle = 1'b1;
    repeat (50) @(negedge clk);
    idle = 1'b0;
    wait_pulse(t0, el);
    check(el == OSC * 2 * STEPS, "R8 idle-run counts", el, OSC * 2 * STEPS);

    wr(8'h87, t0);
    repeat (100) @(negedge clk);
    wr(8'h80, t1);
    wait_pulse(t0, el);
    check(el == OSC * 256 + (STEPS - 1) * OSC * 2, "R9 select at wrap", el,
          OSC * 256 + (STEPS - 1) * OSC * 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule